// File: doc/BRIEF.md
# Bit-Serial Adder with Stored Carry

This block adds two N-bit operands one bit per clock using a single full adder. The augend lives in a right-shifting register that also serves as the accumulator. On each enabled shift, the sum bit from the adder enters that register at its most significant end. The addend lives in a second right-shifting register. That register takes a fresh bit from a serial input on every shift, so a new addend can be streamed in while the old one is consumed. The carry between bit times is held in one D flip-flop.

A typical sequence has four steps:
1. Preload both operands in parallel.
2. Clear the carry flop.
3. Hold the shift enable for N cycles.
4. Read the N-bit sum from the augend register and the carry-out from the carry flop.

A one-cycle done pulse marks the end of the Nth enabled shift. Bits are processed least significant first.

Top module: `serialAdderTop`

## Requirements
- R1: While the active-low reset `rstN` is low, `sumOut`, `addendOut`, `carryOut` and `done` are all 0.
- R2: When `loadEn` is high at a clock edge, `sumOut` takes `augendIn` and `addendOut` takes `addendIn` at that edge. This happens whatever `shiftEn` is, and the bit count restarts.
- R3: When `carryClr` is high at a clock edge, `carryOut` becomes 0 at that edge and the bit count restarts. If `loadEn` is low, neither shift register moves at that edge, even with `shiftEn` high.
- R4: An enabled shift happens at an edge where `shiftEn` is 1 and both `loadEn` and `carryClr` are 0. At such an edge, `sumOut` shifts right by one. Bit N-1 of `sumOut` takes the sum bit of `sumOut[0]`, `addendOut[0]` and `carryOut`. `carryOut` takes the carry of those same three bits.
- R5: On an enabled shift, `addendOut` shifts right by one and its bit N-1 takes `serialIn`.
- R6: At an edge where `shiftEn`, `loadEn` and `carryClr` are all 0, `sumOut`, `addendOut` and `carryOut` keep their values.
- R7: After a load and a carry clear followed by N enabled shifts, `sumOut` equals (A + B) mod 2^N and `carryOut` equals bit N of A + B.
- R8: `done` is high for exactly one cycle, right after the Nth enabled shift since the last load or carry clear. It stays low after earlier shifts.
- R9: With both operands all ones, the result is 2^N - 2 with `carryOut` = 1.
- R10: An addend streamed into `serialIn` over N enabled shifts, least significant bit first, appears whole on `addendOut` after those N shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Parallel load of both operands |
| augendIn | input | N | Augend preload value |
| addendIn | input | N | Addend preload value |
| shiftEn | input | 1 | Shift control, one bit time per cycle |
| carryClr | input | 1 | Synchronous clear of the carry flop |
| serialIn | input | 1 | Serial input of the addend register |
| sumOut | output | N | Augend/accumulator register contents |
| addendOut | output | N | Addend register contents |
| carryOut | output | 1 | Carry flop output |
| done | output | 1 | One-cycle pulse after N enabled shifts |

## Verification
The assertions check every cycle for the single-step behaviour: the per-shift sum and carry relation, the serial refill of the addend register, the hold when idle, the load and clear effects, and the single-cycle width of done. The end-to-end results need the bench's scenarios to show them. Those results are the complete N-bit sum and carry-out, including the all-ones operands. The bench also shows done arriving on exactly the Nth shift, and a whole new addend appearing after a streamed refill.

// File: rtl/serialAdderPkg.sv
package serialAdderPkg;
  typedef struct packed {
    logic load;
    logic clrCarry;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/serialFullAdder.sv
module serialFullAdder (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  always_comb begin
    s = x ^ y ^ z;
    c = (x & y) | (x & z) | (y & z);
  end
endmodule

// File: rtl/serialAdderCtrl.sv
module serialAdderCtrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic loadEn,
  input  logic carryClr,
  input  logic shiftEn,
  output serialAdderPkg::strobe_t strobe,
  output logic done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] bitCnt;
  logic doneQ;

  always_comb begin
    strobe.load     = loadEn;
    strobe.clrCarry = carryClr;
    strobe.shift    = shiftEn & ~loadEn & ~carryClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else if (strobe.load || strobe.clrCarry) begin
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else if (strobe.shift) begin
      if (bitCnt == LAST) begin
        bitCnt <= '0;
        doneQ  <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
        doneQ  <= 1'b0;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign done = doneQ;
endmodule

// File: rtl/serialAdderPath.sv
module serialAdderPath #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rstN,
  input  serialAdderPkg::strobe_t strobe,
  input  logic [N-1:0] augendIn,
  input  logic [N-1:0] addendIn,
  input  logic serialIn,
  output logic [N-1:0] regA,
  output logic [N-1:0] regB,
  output logic carryQ
);
  logic sumBit;
  logic carryBit;

  serialFullAdder fa_i (
    .x(regA[0]),
    .y(regB[0]),
    .z(carryQ),
    .s(sumBit),
    .c(carryBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else if (strobe.load) begin
      regA <= augendIn;
      regB <= addendIn;
    end else if (strobe.shift) begin
      regA <= {sumBit, regA[N-1:1]};
      regB <= {serialIn, regB[N-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
    end else if (strobe.clrCarry) begin
      carryQ <= 1'b0;
    end else if (strobe.shift) begin
      carryQ <= carryBit;
    end
  end
endmodule

// File: rtl/serialAdderTop.sv
module serialAdderTop #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic loadEn,
  input  logic [N-1:0] augendIn,
  input  logic [N-1:0] addendIn,
  input  logic shiftEn,
  input  logic carryClr,
  input  logic serialIn,
  output logic [N-1:0] sumOut,
  output logic [N-1:0] addendOut,
  output logic carryOut,
  output logic done
);
  serialAdderPkg::strobe_t strobe;

  serialAdderCtrl #(.N(N)) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .loadEn(loadEn),
    .carryClr(carryClr),
    .shiftEn(shiftEn),
    .strobe(strobe),
    .done(done)
  );

  serialAdderPath #(.N(N)) path_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .augendIn(augendIn),
    .addendIn(addendIn),
    .serialIn(serialIn),
    .regA(sumOut),
    .regB(addendOut),
    .carryQ(carryOut)
  );
endmodule

// File: rtl/serialAdderChk.sv
module serialAdderChk #(
  parameter int N = 8
) (
  input logic clk,
  input logic rstN,
  input logic loadEn,
  input logic [N-1:0] augendIn,
  input logic [N-1:0] addendIn,
  input logic shiftEn,
  input logic carryClr,
  input logic serialIn,
  input logic [N-1:0] sumOut,
  input logic [N-1:0] addendOut,
  input logic carryOut,
  input logic done
);
  logic isShift;
  logic isIdle;
  assign isShift = shiftEn && !loadEn && !carryClr;
  assign isIdle  = !shiftEn && !loadEn && !carryClr;

  always_comb begin
    if (!rstN) begin
      a_reset_r1: assert (sumOut == '0 && addendOut == '0 && !carryOut && !done);
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (sumOut == $past(augendIn) && addendOut == $past(addendIn)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    carryClr |=> !carryOut);

  p_clr_noshift_r3: assert property (@(posedge clk) disable iff (!rstN)
    (carryClr && !loadEn) |=> ($stable(sumOut) && $stable(addendOut)));

  p_sum_r4: assert property (@(posedge clk) disable iff (!rstN)
    isShift |=> (sumOut[N-1] == ($past(sumOut[0]) ^ $past(addendOut[0]) ^ $past(carryOut))
                 && sumOut[N-2:0] == $past(sumOut[N-1:1])));

  p_serial_r5: assert property (@(posedge clk) disable iff (!rstN)
    isShift |=> (addendOut == {$past(serialIn), $past(addendOut[N-1:1])}));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |=> ($stable(sumOut) && $stable(addendOut) && $stable(carryOut)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(isShift));
endmodule

bind serialAdderTop serialAdderChk #(.N(N)) chk_i (
  .clk(clk),
  .rstN(rstN),
  .loadEn(loadEn),
  .augendIn(augendIn),
  .addendIn(addendIn),
  .shiftEn(shiftEn),
  .carryClr(carryClr),
  .serialIn(serialIn),
  .sumOut(sumOut),
  .addendOut(addendOut),
  .carryOut(carryOut),
  .done(done)
);

// File: tb/serialAdderTop_tb_top.sv
module serialAdderTop_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [N-1:0] augendIn = '0;
  logic [N-1:0] addendIn = '0;
  logic shiftEn = 1'b0;
  logic carryClr = 1'b0;
  logic serialIn = 1'b0;
  logic [N-1:0] sumOut;
  logic [N-1:0] addendOut;
  logic carryOut;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serialAdderTop #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .augendIn(augendIn),
    .addendIn(addendIn), .shiftEn(shiftEn), .carryClr(carryClr),
    .serialIn(serialIn), .sumOut(sumOut), .addendOut(addendOut),
    .carryOut(carryOut), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadAndClear(input logic [N-1:0] a, input logic [N-1:0] b);
    loadEn = 1'b1; augendIn = a; addendIn = b;
    tick();
    loadEn = 1'b0; carryClr = 1'b1;
    tick();
    carryClr = 1'b0;
  endtask

  task automatic tReset();
    check("R1 sumOut", 32'(sumOut), 0);
    check("R1 addendOut", 32'(addendOut), 0);
    check("R1 carryOut", 32'(carryOut), 0);
    check("R1 done", 32'(done), 0);
  endtask

  task automatic tAdd(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] nextB);
    logic [N:0] full;
    full = {1'b0, a} + {1'b0, b};
    loadAndClear(a, b);
    check("R2 load addend", 32'(addendOut), 32'(b));
    check("R3 carry cleared", 32'(carryOut), 0);
    for (int i = 0; i < N; i++) begin
      shiftEn = 1'b1; serialIn = nextB[i];
      tick();
      check("R8 done timing", 32'(done), (i == N - 1) ? 1 : 0);
    end
    shiftEn = 1'b0;
    check("R7 sum", 32'(sumOut), 32'(full[N-1:0]));
    check("R7 carry", 32'(carryOut), 32'(full[N]));
    check("R10 refilled addend", 32'(addendOut), 32'(nextB));
    tick();
    check("R8 done single cycle", 32'(done), 0);
  endtask

  task automatic tAllOnes();
    loadAndClear('1, '1);
    shiftEn = 1'b1; serialIn = 1'b0;
    for (int i = 0; i < N; i++) tick();
    shiftEn = 1'b0;
    check("R9 all ones sum", 32'(sumOut), 32'((1 << N) - 2));
    check("R9 all ones carry", 32'(carryOut), 1);
  endtask

  task automatic tStep();
    loadAndClear(8'h05, 8'h03);
    shiftEn = 1'b1; serialIn = 1'b1;
    tick();
    shiftEn = 1'b0;
    check("R4 step sum reg", 32'(sumOut), 32'h02);
    check("R4 step carry", 32'(carryOut), 1);
    check("R5 step addend", 32'(addendOut), 32'h81);
  endtask

  task automatic tHold();
    logic [N-1:0] a0, b0;
    logic c0;
    a0 = sumOut; b0 = addendOut; c0 = carryOut;
    serialIn = 1'b1;
    tick(); tick(); tick();
    check("R6 hold sum", 32'(sumOut), 32'(a0));
    check("R6 hold addend", 32'(addendOut), 32'(b0));
    check("R6 hold carry", 32'(carryOut), 32'(c0));
  endtask

  task automatic tLoadPriority();
    loadEn = 1'b1; shiftEn = 1'b1; augendIn = 8'h3C; addendIn = 8'hA5; serialIn = 1'b1;
    tick();
    loadEn = 1'b0; shiftEn = 1'b0;
    check("R2 load beats shift A", 32'(sumOut), 32'h3C);
    check("R2 load beats shift B", 32'(addendOut), 32'hA5);
  endtask

  task automatic tClrSuppress();
    loadAndClear(8'hFF, 8'h01);
    shiftEn = 1'b1; serialIn = 1'b0;
    for (int i = 0; i < N; i++) tick();
    shiftEn = 1'b0;
    check("R7 carry set", 32'(carryOut), 1);
    carryClr = 1'b1; shiftEn = 1'b1; serialIn = 1'b1;
    tick();
    carryClr = 1'b0; shiftEn = 1'b0;
    check("R3 clr clears carry", 32'(carryOut), 0);
    check("R3 clr blocks shift A", 32'(sumOut), 0);
    check("R3 clr blocks shift B", 32'(addendOut), 0);
  endtask

  initial begin
    #3;
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tick();
    tReset();
    tStep();
    tHold();
    tAdd(8'h5A, 8'h33, 8'hC7);
    tAdd(8'h80, 8'h80, 8'h01);
    tAdd(8'h00, 8'h00, 8'hFF);
    tAllOnes();
    tLoadPriority();
    tClrSuppress();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule